// File: doc/BRIEF.md
# UART Receive Buffer with Idle Ageing Timer

This block sits behind a UART deserializer and holds received characters until software or a downstream engine fetches them. Each character arrives on a one-cycle strobe together with its framing-error and break indications. The block stores it in a 32-deep FIFO and presents the oldest entry as a 16-bit word on a read port. A one-cycle pop strobe removes that entry. The word carries the character, a valid marker and the error flags.

The block produces two status flags:

- A ready flag compares the fill level against a programmable trigger level.
- An ageing flag catches the case where a few characters sit below the trigger level and nothing happens to the FIFO for eight character times (64 bit periods). Any accepted push or any pop restarts that wait.

The ready flag, gated by its own interrupt enable, and the ageing flag, gated by the timer enable, are ORed into one interrupt line. A push that arrives while the FIFO is full is dropped. The drop sets a sticky overrun flag and marks the newest stored word.

Top module: `uart_rx_fifo_age`

## Requirements
- R1: After reset the fill level is 0, the read word is 16'h0000, and the ready, ageing, overrun and interrupt outputs are all low.
- R2: Entries leave in arrival order. The read word layout is: bit 15 set for a valid entry; bits 7:0 hold the character; bit 12 holds the framing error; bit 11 holds the break; bit 14 is the OR of bits 13, 12 and 11; bits 10:8 are zero.
- R3: When the FIFO is empty the read word is 16'h0000 (valid clear), and a pop leaves the fill level unchanged.
- R4: The FIFO holds 32 entries. A push into a full FIFO without a pop in the same cycle is dropped. The drop sets the overrun flag, which stays set until the overrun-clear input is pulsed. The drop also sets bits 13 and 14 of the newest stored entry.
- R5: The ready flag is high exactly when the fill level is at least the trigger level. A trigger level of 0 acts as 1.
- R6: While the timer is enabled, the FIFO is non-empty and the fill level is below the trigger level, the ageing flag rises exactly 64*BIT_CYCLES clock cycles after the last FIFO activity.
- R7: An accepted push or a pop of a non-empty FIFO restarts the ageing count from zero.
- R8: The ageing count does not advance when the FIFO is empty, when the fill level has reached the trigger level, or when the timer enable is low.
- R9: A pulse on the ageing-clear input clears the ageing flag in the next cycle.
- R10: The interrupt is high when the ready flag is high and the ready interrupt enable is set, or when the ageing flag is high and the timer enable is set.
- R11: A push and a pop in the same cycle on a full FIFO both take effect. The fill level stays at 32 and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_stb | input | 1 | One-cycle strobe: a received character is present |
| rx_char | input | 8 | Received character |
| rx_frame_err | input | 1 | Framing error for this character |
| rx_break | input | 1 | Break condition for this character |
| rd_pop | input | 1 | Remove the head entry |
| rd_word | output | 16 | Head entry in read-word format |
| fill | output | 6 | Number of stored entries |
| trig_level | input | 6 | Receive trigger level |
| age_en | input | 1 | Ageing timer enable |
| rdy_ie | input | 1 | Ready interrupt enable |
| clr_age | input | 1 | Clear the ageing flag |
| clr_ovr | input | 1 | Clear the overrun flag |
| rdy_flag | output | 1 | Fill level at or above trigger |
| age_flag | output | 1 | Ageing timeout occurred |
| ovr_flag | output | 1 | Sticky overrun |
| irq | output | 1 | Combined interrupt |

## Verification
A push and a pop can land in the same cycle. Their interaction is checked in two places:

- With the FIFO at 32 entries, the bench drives a push and a pop on the same edge. It then expects the fill level to stay at 32, the overrun flag to stay clear, and the next push to be dropped and marked on the character that entered in that shared cycle.
- The ageing count and FIFO activity can also coincide. The bench pushes while the count runs and measures the exact edge at which the ageing flag rises, counted from the last activity.

// File: rtl/uart_rx_fifo_age.sv
module uart_rx_fifo_age #(
  parameter int DEPTH      = 32,
  parameter int BIT_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_stb,
  input  logic [7:0]  rx_char,
  input  logic        rx_frame_err,
  input  logic        rx_break,
  input  logic        rd_pop,
  output logic [15:0] rd_word,
  output logic [5:0]  fill,
  input  logic [5:0]  trig_level,
  input  logic        age_en,
  input  logic        rdy_ie,
  input  logic        clr_age,
  input  logic        clr_ovr,
  output logic        rdy_flag,
  output logic        age_flag,
  output logic        ovr_flag,
  output logic        irq
);
  localparam int PW        = $clog2(DEPTH);
  localparam int CW        = $clog2(DEPTH + 1);
  localparam int AGE_LIMIT = 64 * BIT_CYCLES;
  localparam int AW        = $clog2(AGE_LIMIT + 1);

  logic [9:0]       mem_q [DEPTH];
  logic [DEPTH-1:0] ovr_mark_q;
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic [AW-1:0]    age_cnt_q;
  logic             age_q, ovr_q;

  logic empty, full, do_pop, do_push, drop, activity, age_run;
  logic [5:0] trig_eff;

  assign empty    = (cnt_q == '0);
  assign full     = (int'(cnt_q) == DEPTH);
  assign do_pop   = rd_pop & ~empty;
  assign do_push  = rx_stb & (~full | do_pop);
  assign drop     = rx_stb & full & ~do_pop;
  assign activity = do_push | do_pop;
  assign trig_eff = (trig_level == '0) ? 6'd1 : trig_level;
  assign age_run  = age_en & ~empty & (int'(cnt_q) < int'(trig_eff)) & ~age_q;

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= {rx_frame_err, rx_break, rx_char};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      cnt_q      <= '0;
      ovr_mark_q <= '0;
      ovr_q      <= 1'b0;
    end else begin
      if (do_push) begin
        wr_ptr_q             <= wr_ptr_q + 1'b1;
        ovr_mark_q[wr_ptr_q] <= 1'b0;
      end
      if (drop) ovr_mark_q[wr_ptr_q - 1'b1] <= 1'b1;
      if (do_pop) rd_ptr_q <= rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (drop)         ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_cnt_q <= '0;
      age_q     <= 1'b0;
    end else begin
      if (activity || !age_run) begin
        age_cnt_q <= '0;
      end else if (age_cnt_q == AW'(AGE_LIMIT - 1)) begin
        age_cnt_q <= '0;
        age_q     <= 1'b1;
      end else begin
        age_cnt_q <= age_cnt_q + 1'b1;
      end
      if (clr_age) age_q <= 1'b0;
    end
  end

  logic [9:0] head;
  logic       head_ovr;
  assign head     = mem_q[rd_ptr_q];
  assign head_ovr = ovr_mark_q[rd_ptr_q];

  assign rd_word  = empty ? 16'h0000 :
                    {1'b1, head_ovr | head[9] | head[8], head_ovr, head[9], head[8], 3'b000, head[7:0]};
  assign fill     = 6'(cnt_q);
  assign rdy_flag = int'(cnt_q) >= int'(trig_eff);
  assign age_flag = age_q;
  assign ovr_flag = ovr_q;
  assign irq      = (rdy_flag & rdy_ie) | (age_q & age_en);
endmodule

// File: rtl/uart_rx_fifo_age_chk.sv
module uart_rx_fifo_age_chk #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_stb,
  input logic        rd_pop,
  input logic [15:0] rd_word,
  input logic [5:0]  fill,
  input logic        age_en,
  input logic        rdy_ie,
  input logic        clr_age,
  input logic        rdy_flag,
  input logic        age_flag,
  input logic        ovr_flag,
  input logic        irq
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) int'(fill) <= DEPTH); // R4
  AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (!rst_n) fill == 0 |-> rd_word == 16'h0000); // R3
  AST_DROP_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb && int'(fill) == DEPTH && !rd_pop |=> ovr_flag); // R4
  AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) fill == 0 |-> !rdy_flag); // R5
  AST_AGE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) $rose(age_flag) |-> fill != 0); // R6
  AST_PUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb && int'(fill) != DEPTH |=> !$rose(age_flag)); // R7
  AST_AGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_age |=> !age_flag); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !rdy_ie && !age_en |-> !irq); // R10
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb && rd_pop && int'(fill) == DEPTH |=> int'(fill) == DEPTH && !$rose(ovr_flag)); // R11
endmodule

bind uart_rx_fifo_age uart_rx_fifo_age_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rd_pop(rd_pop), .rd_word(rd_word),
  .fill(fill), .age_en(age_en), .rdy_ie(rdy_ie), .clr_age(clr_age),
  .rdy_flag(rdy_flag), .age_flag(age_flag), .ovr_flag(ovr_flag), .irq(irq)
);

// File: tb/uart_rx_fifo_age_tb_top.sv
`timescale 1ns/1ps
module uart_rx_fifo_age_tb_top;
  localparam int BITC  = 4;
  localparam int LIMIT = 64 * BITC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_stb = 0, rx_frame_err = 0, rx_break = 0, rd_pop = 0;
  logic [7:0] rx_char = 0;
  logic [5:0] trig_level = 6'd8;
  logic age_en = 0, rdy_ie = 0, clr_age = 0, clr_ovr = 0;
  logic [15:0] rd_word;
  logic [5:0] fill;
  logic rdy_flag, age_flag, ovr_flag, irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_rx_fifo_age #(.DEPTH(32), .BIT_CYCLES(BITC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_char(rx_char),
    .rx_frame_err(rx_frame_err), .rx_break(rx_break), .rd_pop(rd_pop),
    .rd_word(rd_word), .fill(fill), .trig_level(trig_level), .age_en(age_en),
    .rdy_ie(rdy_ie), .clr_age(clr_age), .clr_ovr(clr_ovr), .rdy_flag(rdy_flag),
    .age_flag(age_flag), .ovr_flag(ovr_flag), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] c, logic fe = 0, logic brk = 0);
    @(negedge clk);
    rx_stb = 1; rx_char = c; rx_frame_err = fe; rx_break = brk;
    @(negedge clk);
    rx_stb = 0; rx_frame_err = 0; rx_break = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd_pop = 1;
    @(negedge clk); rd_pop = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 fill", fill, 0);
    chk("R1 word", rd_word, 0);
    chk("R1 flags", {rdy_flag, age_flag, ovr_flag, irq}, 0);
  endtask

  task automatic t_order();
    trig_level = 8; age_en = 0;
    push(8'h41); push(8'h42, 1, 0); push(8'h43, 0, 1);
    chk("R2 fill", fill, 3);
    chk("R2 plain word", rd_word, 16'h8041); pop();
    chk("R2 frame word", rd_word, 16'hD042); pop();
    chk("R2 break word", rd_word, 16'hC843); pop();
    chk("R3 empty word", rd_word, 16'h0000);
    pop();
    chk("R3 pop on empty fill", fill, 0);
  endtask

  task automatic t_ready();
    trig_level = 3; rdy_ie = 1;
    push(8'h01); push(8'h02);
    chk("R5 below trigger", rdy_flag, 0);
    chk("R10 irq low", irq, 0);
    push(8'h03);
    chk("R5 at trigger", rdy_flag, 1);
    chk("R10 irq ready", irq, 1);
    rdy_ie = 0; idle(1);
    chk("R10 irq masked", irq, 0);
    pop(); pop();
    trig_level = 0; idle(1);
    chk("R5 zero trigger as one", rdy_flag, 1);
    pop();
    chk("R5 empty not ready", rdy_flag, 0);
    trig_level = 8;
  endtask

  task automatic t_age();
    trig_level = 8; age_en = 1;
    push(8'h10);
    idle(LIMIT - 1);
    chk("R6 not yet aged", age_flag, 0);
    idle(1);
    chk("R6 aged", age_flag, 1);
    chk("R10 irq ageing", irq, 1);
    @(negedge clk) clr_age = 1;
    @(negedge clk) clr_age = 0;
    chk("R9 cleared", age_flag, 0);
    idle(200);
    push(8'h11);
    idle(LIMIT - 1);
    chk("R7 restart not aged", age_flag, 0);
    idle(1);
    chk("R7 restart aged", age_flag, 1);
    @(negedge clk) clr_age = 1;
    @(negedge clk) clr_age = 0;
    pop(); pop();
    trig_level = 1; push(8'h12);
    idle(LIMIT + 10);
    chk("R8 at trigger no ageing", age_flag, 0);
    pop(); idle(LIMIT + 10);
    chk("R8 empty no ageing", age_flag, 0);
    trig_level = 8; age_en = 0; push(8'h13);
    idle(LIMIT + 10);
    chk("R8 disabled no ageing", age_flag, 0);
    pop();
  endtask

  task automatic t_full();
    trig_level = 8; age_en = 0;
    for (int i = 0; i < 32; i++) push(8'(i));
    chk("R4 full", fill, 32);
    chk("R4 no overrun yet", ovr_flag, 0);
    @(negedge clk); rx_stb = 1; rx_char = 8'h80; rd_pop = 1;
    @(negedge clk); rx_stb = 0; rd_pop = 0;
    chk("R11 fill kept", fill, 32);
    chk("R11 no overrun", ovr_flag, 0);
    chk("R11 head advanced", rd_word, 16'h8001);
    push(8'h81);
    chk("R4 dropped fill", fill, 32);
    chk("R4 overrun set", ovr_flag, 1);
    idle(3);
    chk("R4 overrun sticky", ovr_flag, 1);
    @(negedge clk) clr_ovr = 1;
    @(negedge clk) clr_ovr = 0;
    chk("R4 overrun cleared", ovr_flag, 0);
    for (int i = 1; i < 32; i++) begin
      chk("R2 drain order", rd_word, 32'h8000 | i);
      pop();
    end
    chk("R4 newest marked", rd_word, 16'hE080);
    pop();
    chk("R3 drained", fill, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk) rst_n = 1;
    idle(2);
    t_order();
    t_ready();
    t_age();
    t_full();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule